// File: doc/BRIEF.md
# Reloadable Real-Time Clock Core

This block keeps time of day in hours, minutes and seconds. Its timebase is a software-loaded sub-second down counter. The block halves a single count-enable input internally. Each halved enable steps the down counter once. When the down counter has reached zero, the next step reloads it and signals that half a second has elapsed. Every second half-second signal advances the seconds counter, which carries into minutes and then into hours.

Software reaches the block through a simple word-wide register port: a write strobe with address and data, and a combinational read port with its own address. Software writes a reload value and preset time values, then sets a start bit. Clearing the start bit stops the clock and zeroes all counters. Setting it again copies the presets and the reload value into the running counters. Five sticky event flags, each with its own enable, drive a single interrupt output.

Top module: `rtc_core`

## Requirements
- R1: Register map (word addresses): 0 control (bit0 start, read/write; bit1 run, read-only), 1 reload [20:0], 2 second preset [5:0], 3 minute preset [5:0], 4 hour preset [4:0], 5 event flags [4:0], 6 flag enables [4:0], 7 live time {hour at [20:16], minute at [13:8], second at [5:0]}, 8 live down counter [20:0]. Reads are combinational, and after reset every register reads 0.
- R2: While start is 0, the down counter, the time counters and the run bit read 0, and count-enable pulses have no effect. Writing start=0 zeroes them at that write's clock edge.
- R3: Writing the reload or preset registers leaves the live counters unchanged.
- R4: A write of start=1 while start is 0 copies the presets into the time counters and the reload value into the down counter, and sets run, all at that write's edge.
- R5: A write of start=1 while already running reloads nothing. Time and down counter keep their values.
- R6: The down counter steps once per two count-enable pulses. The first step occurs on the second pulse after start.
- R7: A step taken while the down counter is 0 reloads it from the reload register and produces a half-second event. With reload value N, one half-second therefore spans 2(N+1) pulses.
- R8: Every second half-second event increments seconds. The half-second phase is cleared at start, so the first second after a start comes after 4(N+1) pulses.
- R9: Seconds and minutes that are 59 or more wrap to 0 on increment and carry into the next counter. Hours that are 23 or more wrap to 0.
- R10: Flag bits: 0 half-second, 1 second, 2 seconds wrapped, 3 minutes wrapped, 4 hours wrapped. Each flag is set by its event and stays set. A write to address 5 clears each bit written as 0 and leaves each bit written as 1. An event in the same cycle as a clearing write wins.
- R11: irq_o is 1 exactly when some flag bit and its enable bit are both 1.
- R12: Stopping the clock does not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable pulse, halved internally |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Interrupt, OR of enabled flags |

## Verification
The bench runs the clock with several reload values (0, 1, 2, 5) and presets placed just before minute, hour and day rollovers. After every pulse it compares the down counter, the time and the flags against closed-form arithmetic on the pulse count; this separates off-by-one errors in the enable halving, the reload point and the carry chain. One run is stopped at an odd half-second and then restarted, which shows whether the half-second phase is cleared. An out-of-range preset (hour 30, second 62) checks the wrap-on-or-above rule. A repeated start and a flag write with mixed bits check that both are ignored where they should be.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W    = 4;
    localparam int SEC_W     = 6;
    localparam int MIN_W     = 6;
    localparam int HR_W      = 5;
    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HR_LAST   = 23;
    localparam int NUM_FLAGS = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 4'd0,
        RA_RELOAD = 4'd1,
        RA_PSEC   = 4'd2,
        RA_PMIN   = 4'd3,
        RA_PHR    = 4'd4,
        RA_FLAG   = 4'd5,
        RA_IEN    = 4'd6,
        RA_TIME   = 4'd7,
        RA_DCNT   = 4'd8
    } reg_addr_e;

    // Event vector, packed so that half-second lands on bit 0.
    typedef struct packed {
        logic day;
        logic hour;
        logic minute;
        logic second;
        logic half;
    } evt_t;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } tod_t;

    function automatic logic [31:0] pack_time(input tod_t t);
        logic [31:0] w;
        w        = '0;
        w[20:16] = t.hr;
        w[13:8]  = t.mn;
        w[5:0]   = t.sc;
        return w;
    endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
    parameter int DCNT_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              active,
    input  logic              cnt_en,
    input  logic [DCNT_W-1:0] reload_val,
    output logic [DCNT_W-1:0] dcnt_o,
    output logic              half_evt_o,
    output logic              sec_evt_o
);
    logic              pre_q;
    logic              hp_q;
    logic [DCNT_W-1:0] dcnt_q;
    logic              step;
    logic              at_zero;

    assign step       = active && cnt_en && pre_q;
    assign at_zero    = (dcnt_q == '0);
    assign half_evt_o = step && at_zero;
    assign sec_evt_o  = half_evt_o && hp_q;
    assign dcnt_o     = dcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= 1'b0;
            hp_q   <= 1'b0;
            dcnt_q <= '0;
        end else if (load) begin
            pre_q  <= 1'b0;
            hp_q   <= 1'b0;
            dcnt_q <= reload_val;
        end else if (!active) begin
            pre_q  <= 1'b0;
            hp_q   <= 1'b0;
            dcnt_q <= '0;
        end else begin
            if (cnt_en) begin
                pre_q <= ~pre_q;
            end
            if (step) begin
                dcnt_q <= at_zero ? reload_val : dcnt_q - DCNT_W'(1);
            end
            if (half_evt_o) begin
                hp_q <= ~hp_q;
            end
        end
    end
endmodule

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
    parameter int W    = 6,
    parameter int LAST = 59
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         active,
    input  logic         inc,
    output logic [W-1:0] val_o,
    output logic         carry_o
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    logic [W-1:0] val_q;
    logic         at_last;

    assign at_last = (val_q >= LAST_V);
    assign carry_o = active && inc && at_last;
    assign val_o   = val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (load) begin
            val_q <= load_val;
        end else if (!active) begin
            val_q <= '0;
        end else if (inc) begin
            val_q <= at_last ? '0 : val_q + W'(1);
        end
    end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         wr_flag,
    input  logic         wr_ien,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] ien_o,
    output logic         irq_o
);
    logic [N-1:0] flags_q;
    logic [N-1:0] ien_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else if (evt[i]) begin
                flags_q[i] <= 1'b1;
            end else if (wr_flag && !wdata[i]) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (wr_ien) begin
            ien_q <= wdata;
        end
    end

    assign flags_o = flags_q;
    assign ien_o   = ien_q;
    assign irq_o   = |(flags_q & ien_q);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DCNT_W = 21,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    logic [DCNT_W-1:0] reload_q;
    logic [SEC_W-1:0]  psec_q;
    logic [MIN_W-1:0]  pmin_q;
    logic [HR_W-1:0]   phr_q;
    logic              start_r;
    logic              run_r;

    logic              wr_ctrl;
    logic              load_go;
    logic              stop_go;
    logic              active;

    logic [DCNT_W-1:0] dcnt_q;
    logic              half_evt;
    logic              sec_evt;
    logic [SEC_W-1:0]  sec_q;
    logic [MIN_W-1:0]  min_q;
    logic [HR_W-1:0]   hr_q;
    logic              sec_wrap;
    logic              min_wrap;
    logic              hr_wrap;
    evt_t              evt;
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] ien_q;
    tod_t              now;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:DCNT_W];

    assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);
    assign load_go = wr_ctrl && wr_data[0] && !start_r;
    assign stop_go = wr_ctrl && !wr_data[0];
    assign active  = start_r && !stop_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            psec_q   <= '0;
            pmin_q   <= '0;
            phr_q    <= '0;
            start_r  <= 1'b0;
            run_r    <= 1'b0;
        end else begin
            if (wr_en && wr_addr == RA_RELOAD) reload_q <= wr_data[DCNT_W-1:0];
            if (wr_en && wr_addr == RA_PSEC)   psec_q   <= wr_data[SEC_W-1:0];
            if (wr_en && wr_addr == RA_PMIN)   pmin_q   <= wr_data[MIN_W-1:0];
            if (wr_en && wr_addr == RA_PHR)    phr_q    <= wr_data[HR_W-1:0];
            if (wr_ctrl) start_r <= wr_data[0];
            if (load_go) begin
                run_r <= 1'b1;
            end else if (stop_go) begin
                run_r <= 1'b0;
            end
        end
    end

    rtc_subsec #(.DCNT_W(DCNT_W)) u_sub (
        .clk        (clk),
        .rst        (rst),
        .load       (load_go),
        .active     (active),
        .cnt_en     (cnt_en),
        .reload_val (reload_q),
        .dcnt_o     (dcnt_q),
        .half_evt_o (half_evt),
        .sec_evt_o  (sec_evt)
    );

    rtc_wrap_cnt #(.W(SEC_W), .LAST(SEC_LAST)) u_sec (
        .clk      (clk),
        .rst      (rst),
        .load     (load_go),
        .load_val (psec_q),
        .active   (active),
        .inc      (sec_evt),
        .val_o    (sec_q),
        .carry_o  (sec_wrap)
    );

    rtc_wrap_cnt #(.W(MIN_W), .LAST(MIN_LAST)) u_min (
        .clk      (clk),
        .rst      (rst),
        .load     (load_go),
        .load_val (pmin_q),
        .active   (active),
        .inc      (sec_wrap),
        .val_o    (min_q),
        .carry_o  (min_wrap)
    );

    rtc_wrap_cnt #(.W(HR_W), .LAST(HR_LAST)) u_hr (
        .clk      (clk),
        .rst      (rst),
        .load     (load_go),
        .load_val (phr_q),
        .active   (active),
        .inc      (min_wrap),
        .val_o    (hr_q),
        .carry_o  (hr_wrap)
    );

    always_comb begin
        evt.half   = half_evt;
        evt.second = sec_evt;
        evt.minute = sec_wrap;
        evt.hour   = min_wrap;
        evt.day    = hr_wrap;
    end

    rtc_irq #(.N(NUM_FLAGS)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .wr_flag (wr_en && wr_addr == RA_FLAG),
        .wr_ien  (wr_en && wr_addr == RA_IEN),
        .wdata   (wr_data[NUM_FLAGS-1:0]),
        .flags_o (flags_q),
        .ien_o   (ien_q),
        .irq_o   (irq_o)
    );

    always_comb begin
        now.hr = hr_q;
        now.mn = min_q;
        now.sc = sec_q;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL:   rd_data = DATA_W'({run_r, start_r});
            RA_RELOAD: rd_data = DATA_W'(reload_q);
            RA_PSEC:   rd_data = DATA_W'(psec_q);
            RA_PMIN:   rd_data = DATA_W'(pmin_q);
            RA_PHR:    rd_data = DATA_W'(phr_q);
            RA_FLAG:   rd_data = DATA_W'(flags_q);
            RA_IEN:    rd_data = DATA_W'(ien_q);
            RA_TIME:   rd_data = DATA_W'(pack_time(now));
            RA_DCNT:   rd_data = DATA_W'(dcnt_q);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
    parameter int DCNT_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic              active,
    input logic              load_go,
    input logic              run_r,
    input logic              half_evt,
    input logic              sec_evt,
    input logic [DCNT_W-1:0] dcnt_q,
    input logic [DCNT_W-1:0] reload_q,
    input logic [5:0]        sec_q,
    input logic [5:0]        min_q,
    input logic [4:0]        hr_q,
    input logic [5:0]        psec_q,
    input logic [5:0]        pmin_q,
    input logic [4:0]        phr_q,
    input logic [4:0]        evt_bits,
    input logic [4:0]        flags_q
);
    // R2: a stopped clock holds every counter at zero
    a_r2_stop_zero: assert property (@(posedge clk) disable iff (rst)
        (!active && !load_go) |=> (dcnt_q == '0 && sec_q == '0 && min_q == '0
                                   && hr_q == '0 && !run_r));

    // R4: start copies presets and reload into the live counters
    a_r4_start_load: assert property (@(posedge clk) disable iff (rst)
        load_go |=> (sec_q == $past(psec_q) && min_q == $past(pmin_q)
                     && hr_q == $past(phr_q) && dcnt_q == $past(reload_q) && run_r));

    // R6: no count-enable pulse, no change of the down counter
    a_r6_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
        (active && !load_go && !cnt_en) |=> $stable(dcnt_q));

    // R7: a half-second event reloads the down counter
    a_r7_reload_at_zero: assert property (@(posedge clk) disable iff (rst)
        (active && half_evt) |=> (dcnt_q == $past(reload_q)));

    // R9: seconds at or above 59 wrap to zero
    a_r9_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (active && sec_evt && sec_q >= 6'd59) |=> (sec_q == 6'd0));

    // R10: a flag only rises on its event
    a_r10_flag_source: assert property (@(posedge clk) disable iff (rst)
        (evt_bits == 5'd0) |=> ((flags_q & ~$past(flags_q)) == 5'd0));
endmodule

bind rtc_core rtc_core_chk #(.DCNT_W(DCNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .active   (active),
    .load_go  (load_go),
    .run_r    (run_r),
    .half_evt (half_evt),
    .sec_evt  (sec_evt),
    .dcnt_q   (dcnt_q),
    .reload_q (reload_q),
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hr_q     (hr_q),
    .psec_q   (psec_q),
    .pmin_q   (pmin_q),
    .phr_q    (phr_q),
    .evt_bits (evt),
    .flags_q  (flags_q)
);

// File: tb/sim_rtc_core.sv
`timescale 1ns/100ps
module sim_rtc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_CTRL = 4'd0, A_RLD = 4'd1, A_PS = 4'd2, A_PM = 4'd3,
                           A_PH = 4'd4, A_FLG = 4'd5, A_IEN = 4'd6, A_TIME = 4'd7,
                           A_DCNT = 4'd8;

    always #5 clk = ~clk;

    rtc_core u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #0.2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a; #0.2;
        d = rd_data;
    endtask

    task automatic pulse();
        @(negedge clk);
        cnt_en = 1'b1;
        @(posedge clk); #0.2;
        cnt_en = 1'b0;
    endtask

    function automatic logic [31:0] tword(input int tot);
        int t;
        t = tot % 86400;
        return ((t / 3600) << 16) | (((t / 60) % 60) << 8) | (t % 60);
    endfunction

    task automatic run_cfg(input int r, input int h, input int m, input int s,
                           input int np, input int mid);
        logic [31:0] d;
        int t0, st, hv, sc, ph, ps, ef, t;
        wr(A_CTRL, 0);
        wr(A_FLG, 0);
        wr(A_IEN, 32'h1f);
        wr(A_RLD, r);
        wr(A_PS, s); wr(A_PM, m); wr(A_PH, h);
        rd(A_TIME, d); chk("R3 presets leave time", d, 0);
        rd(A_DCNT, d); chk("R3 reload leaves dcnt", d, 0);
        wr(A_CTRL, 1);
        rd(A_CTRL, d); chk("R4 run set", d, 3);
        rd(A_TIME, d); chk("R4 time loaded", d, tword(h*3600 + m*60 + s));
        rd(A_DCNT, d); chk("R4 dcnt loaded", d, r);
        t0 = h*3600 + m*60 + s;
        ph = 0; ps = 0; ef = 0;
        for (int n = 1; n <= np; n++) begin
            pulse();
            st = n / 2;
            hv = st / (r + 1);
            sc = hv / 2;
            if (hv > ph) ef |= 1;
            if (sc > ps) begin
                ef |= 2;
                t = t0 + sc;
                if (t % 60 == 0) ef |= 4;
                if (t % 3600 == 0) ef |= 8;
                if (t % 86400 == 0) ef |= 16;
            end
            ph = hv; ps = sc;
            rd(A_DCNT, d);
            chk((st > 0 && st % (r + 1) == 0) ? "R7 reload at zero" : "R6 halved step",
                d, r - (st % (r + 1)));
            rd(A_TIME, d);
            chk((sc > 0) ? "R9 carry chain" : "R8 seconds from halves", d, tword(t0 + sc));
            rd(A_FLG, d); chk("R10 flags", d, ef);
            chk("R11 irq", {31'b0, irq_o}, {31'b0, ef != 0});
            if (n == mid) begin
                wr(A_CTRL, 1);
                rd(A_DCNT, d); chk("R5 restart keeps dcnt", d, r - (st % (r + 1)));
                rd(A_TIME, d); chk("R5 restart keeps time", d, tword(t0 + sc));
            end
        end
        wr(A_CTRL, 0);
        rd(A_FLG, d); chk("R12 flags survive stop", d, ef);
        rd(A_TIME, d); chk("R2 stop clears time", d, 0);
        rd(A_CTRL, d); chk("R2 stop clears run", d, 0);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #0.2 rst = 1'b0;
        // R1: reset values through the register map
        for (int a = 0; a <= 8; a++) begin
            rd(a[3:0], d); chk("R1 reset value", d, 0);
        end
        chk("R1 reset irq", {31'b0, irq_o}, 0);

        // R2: pulses while stopped do nothing
        wr(A_RLD, 3); wr(A_PS, 10);
        for (int i = 0; i < 5; i++) pulse();
        rd(A_TIME, d); chk("R2 stopped time", d, 0);
        rd(A_DCNT, d); chk("R2 stopped dcnt", d, 0);

        run_cfg(0, 23, 59, 57, 16, 0);
        run_cfg(1, 10, 59, 58, 24, 9);
        run_cfg(5, 5, 6, 7, 60, 30);
        run_cfg(2, 12, 34, 59, 30, 11);
        run_cfg(0, 0, 0, 0, 6, 0);    // stop on an odd half-second
        run_cfg(0, 0, 0, 0, 10, 0);   // R8 phase cleared by the restart

        // R9: out-of-range presets wrap on the first increment
        wr(A_FLG, 0);
        wr(A_RLD, 0); wr(A_PS, 62); wr(A_PM, 59); wr(A_PH, 30);
        wr(A_CTRL, 1);
        for (int i = 0; i < 4; i++) pulse();
        rd(A_TIME, d); chk("R9 out-of-range wrap", d, 0);
        rd(A_FLG, d); chk("R9 all rollovers flagged", d, 32'h1f);
        for (int i = 0; i < 4; i++) pulse();
        rd(A_TIME, d); chk("R9 counts on after wrap", d, 1);

        // R10: write 0 clears, write 1 leaves
        wr(A_CTRL, 0);
        wr(A_FLG, 32'h1d);
        rd(A_FLG, d); chk("R10 clear one bit", d, 32'h1d);
        wr(A_FLG, 32'h1f);
        rd(A_FLG, d); chk("R10 write one no effect", d, 32'h1d);
        // R11: enables gate the interrupt
        wr(A_IEN, 0);
        chk("R11 all disabled", {31'b0, irq_o}, 0);
        wr(A_IEN, 32'h02);
        chk("R11 enabled bit clear", {31'b0, irq_o}, 0);
        wr(A_IEN, 32'h04);
        chk("R11 enabled bit set", {31'b0, irq_o}, 1);
        rd(A_IEN, d); chk("R1 enable readback", d, 32'h04);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule